// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table that sits in ordinary memory. Pages are 1 KB. The ten lowest address bits pass through unchanged, and the 22 bits above them form the page number. That page number is split into a 12-bit index into the root table and a 10-bit index into a second-level table. A root register, loaded through its own write strobe, gives the byte address of the root table.

A client presents a virtual address, an access kind (read, write or execute) and a privilege flag. The walker takes one request at a time and reads the root entry through a simple read port. It then reads the leaf entry and checks the leaf against the requested right and privilege. The result is either a physical address or a fault code. The response stays up until the client acknowledges it. Read data returns one cycle after each read request.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle (`req_ready`=1, `busy`=0, `rsp_valid`=0, `mem_rd_en`=0) and the root register holds 0.
- R2: The first read goes to `root + 4*va[31:20]`. When that entry is valid, the second read goes to `{entry[31:10],10'b0} + 4*va[19:10]`.
- R3: A permitted access answers with `rsp_fault`=0 and `rsp_paddr = {leaf[31:10], va[9:0]}`.
- R4: Table entries are 32 bits. Bit 0 = valid, bit 1 = readable, bit 2 = writable, bit 3 = executable, bit 4 = user-accessible, bits 31:10 = table or frame base. Bits 9:5 are ignored.
- R5: A clear valid bit at either level answers with `rsp_fault`=1 (not present). A clear valid bit in the root entry ends the walk after a single read.
- R6: Access codes are 0 = read, 1 = write, 2 = execute. A valid leaf that lacks the requested right, or a user request (`req_user`=1) to a page whose user bit is clear, answers with `rsp_fault`=2 (protection). Supervisor requests ignore the user bit. Access code 3 always gives a protection fault.
- R7: Only one request is in flight. `req_ready` is low from the cycle after acceptance until the response is acknowledged, and requests presented in that time are ignored.
- R8: `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady until a cycle with `rsp_ack` high. After that cycle the walker is idle again.
- R9: A root write takes effect only while the walker is idle. A write strobed while busy is dropped.
- R10: A full walk makes exactly two reads, and `rsp_valid` rises three clock edges after the accepting edge. A walk that stops at the root makes one read and responds after two edges.
- R11: A faulted response carries `rsp_paddr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_we | input | 1 | Root register write strobe |
| root_wdata | input | 32 | New root table address |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| busy | output | 1 | A walk or a pending response is in progress |
| mem_rd_en | output | 1 | Table read request |
| mem_rd_addr | output | 32 | Table entry byte address |
| mem_rd_data | input | 32 | Entry data, one cycle after the request |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_ack | input | 1 | Response taken |

## Verification
The bench targets a root entry with its valid bit clear. A walker that ignored this bit would issue a second read, land on a junk leaf and report the wrong fault or the wrong latency. It also separates user-bit refusals from missing-right refusals, and checks supervisor requests on non-user pages. A walker that compared the wrong flag would either translate a forbidden access or refuse a legal one. The all-ones indices and offset expose a shift or carry slip in the entry address or the physical address. A second request and a root write arrive while the walker is busy, and acknowledgement of a response is delayed. These catch a walker that restarts, changes its table root mid-walk, or lets its response drift before acknowledgement.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned OFF_W     = 10;
    localparam int unsigned L2_IDX_W  = 10;
    localparam int unsigned L1_IDX_W  = ADDR_W - OFF_W - L2_IDX_W;
    localparam int unsigned FRAME_W   = ADDR_W - OFF_W;
    localparam int unsigned FLAG_W    = 5;
    localparam int unsigned RSVD_W    = OFF_W - FLAG_W;
    localparam int unsigned ENT_SHIFT = 2;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PERM   = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_L1,
        ST_FETCH_L2,
        ST_CHECK,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic user;
        logic exec;
        logic write;
        logic read;
        logic valid;
    } pte_flags_t;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [RSVD_W-1:0]  rsvd;
        pte_flags_t         flags;
    } pte_t;

    typedef struct packed {
        logic [L1_IDX_W-1:0] l1;
        logic [L2_IDX_W-1:0] l2;
        logic [OFF_W-1:0]    off;
    } vaddr_t;

    function automatic logic [ADDR_W-1:0] scale_index(input logic [L1_IDX_W-1:0] idx);
        return {{(ADDR_W-L1_IDX_W-ENT_SHIFT){1'b0}}, idx, {ENT_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              idle,
    output logic [ADDR_W-1:0] root_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            root_q <= '0;
        end else if (we && idle) begin
            root_q <= wdata;
        end
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0]  root,
    input  vaddr_t             va,
    input  logic [FRAME_W-1:0] ent_frame,
    output logic [ADDR_W-1:0]  l1_addr,
    output logic [ADDR_W-1:0]  l2_addr,
    output logic [ADDR_W-1:0]  paddr
);
    logic [L1_IDX_W-1:0] l2_idx_wide;

    always_comb begin
        l2_idx_wide = {{(L1_IDX_W-L2_IDX_W){1'b0}}, va.l2};
        l1_addr     = root + scale_index(va.l1);
        l2_addr     = {ent_frame, {OFF_W{1'b0}}} + scale_index(l2_idx_wide);
        paddr       = {ent_frame, va.off};
    end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  pte_flags_t flags,
    input  acc_e       acc,
    input  logic       user,
    output fault_e     fault
);
    logic right_ok;

    always_comb begin
        case (acc)
            ACC_READ:  right_ok = flags.read;
            ACC_WRITE: right_ok = flags.write;
            ACC_EXEC:  right_ok = flags.exec;
            default:   right_ok = 1'b0;
        endcase
        if (!flags.valid) begin
            fault = FLT_ABSENT;
        end else if (!right_ok || (user && !flags.user)) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              root_we,
    input  logic [ADDR_W-1:0] root_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic              req_user,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_fault,
    input  logic              rsp_ack
);
    walk_st_e          state_q;
    vaddr_t            va_q;
    acc_e              acc_q;
    logic              user_q;
    logic [ADDR_W-1:0] root_q;
    logic [ADDR_W-1:0] paddr_q;
    fault_e            fault_q;

    pte_t              rd_pte;
    logic [ADDR_W-1:0] l1_addr;
    logic [ADDR_W-1:0] l2_addr;
    logic [ADDR_W-1:0] leaf_paddr;
    fault_e            leaf_fault;
    logic              unused_rsvd_bits;

    assign rd_pte           = pte_t'(mem_rd_data);
    assign unused_rsvd_bits = ^rd_pte.rsvd;

    ptw_root_reg u_root (
        .clk    (clk),
        .rst    (rst),
        .we     (root_we),
        .wdata  (root_wdata),
        .idle   (state_q == ST_IDLE),
        .root_q (root_q)
    );

    ptw_addr_gen u_addr (
        .root      (root_q),
        .va        (va_q),
        .ent_frame (rd_pte.frame),
        .l1_addr   (l1_addr),
        .l2_addr   (l2_addr),
        .paddr     (leaf_paddr)
    );

    ptw_perm_check u_perm (
        .flags (rd_pte.flags),
        .acc   (acc_q),
        .user  (user_q),
        .fault (leaf_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            acc_q   <= ACC_READ;
            user_q  <= 1'b0;
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= vaddr_t'(req_vaddr);
                        acc_q   <= acc_e'(req_acc);
                        user_q  <= req_user;
                        state_q <= ST_FETCH_L1;
                    end
                end
                ST_FETCH_L1: state_q <= ST_FETCH_L2;
                ST_FETCH_L2: begin
                    if (!rd_pte.flags.valid) begin
                        fault_q <= FLT_ABSENT;
                        paddr_q <= '0;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    fault_q <= leaf_fault;
                    paddr_q <= (leaf_fault == FLT_NONE) ? leaf_paddr : '0;
                    state_q <= ST_DONE;
                end
                ST_DONE: begin
                    if (rsp_ack) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        busy        = (state_q != ST_IDLE);
        rsp_valid   = (state_q == ST_DONE);
        rsp_paddr   = paddr_q;
        rsp_fault   = fault_q;
        mem_rd_en   = (state_q == ST_FETCH_L1) ||
                      ((state_q == ST_FETCH_L2) && rd_pte.flags.valid);
        mem_rd_addr = (state_q == ST_FETCH_L1) ? l1_addr : l2_addr;
    end
endmodule

// File: rtl/ptw_walker_sva.sv
module ptw_walker_sva
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              mem_rd_en,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [1:0]        rsp_fault,
    input logic              rsp_ack,
    input logic [ADDR_W-1:0] root_q,
    input logic [OFF_W-1:0]  va_off
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_rd_en && !rsp_valid));

    a_r7_accept_locks: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (busy && !req_ready));

    a_r8_hold_rsp: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ack) |=> (!rsp_valid && !busy));

    a_r9_root_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(root_q));

    a_r11_fault_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

    a_r3_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[OFF_W-1:0] == va_off));

    a_r6_fault_code: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault != 2'd3));
endmodule

bind ptw_walker ptw_walker_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .mem_rd_en (mem_rd_en),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .rsp_ack   (rsp_ack),
    .root_q    (root_q),
    .va_off    (va_q[9:0])
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        root_we;
    logic [31:0] root_wdata;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [1:0]  req_acc;
    logic        req_user;
    logic        busy;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        rsp_ack;

    always #5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst(rst), .root_we(root_we), .root_wdata(root_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .req_user(req_user), .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_ack(rsp_ack)
    );

    // ---------------- memory model and read log ----------------
    logic [31:0] mem [logic [31:0]];
    logic [31:0] rd_log [int];
    int          rd_total = 0;
    int          cyc = 0;

    function automatic logic [31:0] mem_get(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_en) begin
            mem_rd_data      <= mem_get(mem_rd_addr);
            rd_log[rd_total] = mem_rd_addr;
            rd_total         <= rd_total + 1;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [31:0] paddr;
        logic [1:0]  fault;
        int          nreads;
        int          lat;
        logic [31:0] a1;
        logic [31:0] a2;
        int          ack_delay;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    int          done_cnt = 0;
    int          last_accept = 0;
    int          last_rd_base = 0;
    logic [31:0] tb_root = 32'h0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] va, input logic [1:0] acc, input logic user,
                                   input int ack_delay, input string req);
        exp_t e;
        logic [31:0] e1, e2;
        logic ok;
        e.ack_delay = ack_delay;
        e.req       = req;
        e.a1        = tb_root + {18'h0, va[31:20], 2'b00};
        e1          = mem_get(e.a1);
        e.a2        = {e1[31:10], 10'h0} + {20'h0, va[19:10], 2'b00};
        e.paddr     = 32'h0;
        if (!e1[0]) begin
            e.fault = 2'd1; e.nreads = 1; e.lat = 2;
        end else begin
            e2       = mem_get(e.a2);
            e.nreads = 2; e.lat = 3;
            case (acc)
                2'd0: ok = e2[1];
                2'd1: ok = e2[2];
                2'd2: ok = e2[3];
                default: ok = 1'b0;
            endcase
            if (!e2[0]) e.fault = 2'd1;
            else if (!ok || (user && !e2[4])) e.fault = 2'd2;
            else begin
                e.fault = 2'd0;
                e.paddr = {e2[31:10], va[9:0]};
            end
        end
        return e;
    endfunction

    // monitor: pops and compares when the design responds
    initial begin
        rsp_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && rsp_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R7 unexpected response", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    logic [31:0] held;
                    e = sb_q.pop_front();
                    check(rsp_fault == e.fault, e.req, {30'h0, rsp_fault}, {30'h0, e.fault});
                    check(rsp_paddr == e.paddr, e.req, rsp_paddr, e.paddr);
                    check(cyc - last_accept == e.lat, "R10 latency", cyc - last_accept, e.lat);
                    check(rd_total - last_rd_base == e.nreads, "R10 read count",
                          rd_total - last_rd_base, e.nreads);
                    check(rd_log[last_rd_base] == e.a1, "R2 first read address",
                          rd_log[last_rd_base], e.a1);
                    if (e.nreads == 2)
                        check(rd_log[last_rd_base + 1] == e.a2, "R2 second read address",
                              rd_log[last_rd_base + 1], e.a2);
                    held = rsp_paddr;
                    for (int k = 0; k < e.ack_delay; k++) begin
                        @(negedge clk);
                        check(rsp_valid && rsp_paddr == held, "R8 response held",
                              rsp_paddr, held);
                    end
                    rsp_ack = 1'b1;
                    @(negedge clk);
                    rsp_ack = 1'b0;
                    check(!rsp_valid && req_ready, "R8 released after ack",
                          {30'h0, rsp_valid, req_ready}, 32'h1);
                end
                done_cnt++;
            end
        end
    end

    // driver
    task automatic send(input logic [31:0] va, input logic [1:0] acc, input logic user,
                        input int ack_delay, input string req, input bit busy_test);
        int target;
        exp_t e;
        e = model(va, acc, user, ack_delay, req);
        sb_q.push_back(e);
        target       = done_cnt + 1;
        last_rd_base = rd_total;
        req_vaddr    = va;
        req_acc      = acc;
        req_user     = user;
        req_valid    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        last_accept = cyc;
        if (busy_test) begin
            req_vaddr  = 32'h0020_0000;
            req_acc    = 2'd1;
            root_we    = 1'b1;
            root_wdata = 32'h0;
            check(!req_ready && busy, "R7 ready low while busy", {31'h0, req_ready}, 32'h0);
            @(negedge clk);
            root_we = 1'b0;
            check(!req_ready, "R7 ready low while busy", {31'h0, req_ready}, 32'h0);
        end
        req_valid = 1'b0;
        wait (done_cnt == target);
        @(negedge clk);
    endtask

    task automatic write_root(input logic [31:0] v);
        root_we    = 1'b1;
        root_wdata = v;
        @(negedge clk);
        root_we = 1'b0;
        tb_root = v;
    endtask

    function automatic logic [31:0] mkva(input logic [11:0] i1, input logic [9:0] i2, input logic [9:0] off);
        return {i1, i2, off};
    endfunction

    initial begin
        rst = 1'b1; root_we = 1'b0; root_wdata = '0; req_valid = 1'b0;
        req_vaddr = '0; req_acc = '0; req_user = 1'b0;
        mem[32'h0000_0008] = 32'h0002_0000;
        mem[32'h0001_000C] = 32'h0002_0001;
        mem[32'h0002_0014] = 32'h1234_5400 | 32'h17;
        mem[32'h0002_0018] = 32'h0ABC_DC00 | 32'h0B;
        mem[32'h0002_001C] = 32'h0555_5400 | 32'h1E;
        mem[32'h0001_3FFC] = 32'h0003_0001;
        mem[32'h0003_0FFC] = 32'hFFFF_FC03;
        mem[32'h0004_000C] = 32'h0005_0001;
        mem[32'h0005_0014] = 32'h0777_7C00 | 32'h13;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready && !busy && !rsp_valid && !mem_rd_en, "R1 reset state",
              {28'h0, req_ready, busy, rsp_valid, mem_rd_en}, 32'h8);
        // R1 root is 0, R5 root entry invalid ends walk after one read
        send(mkva(12'd2, 10'd0, 10'd0), 2'd0, 1'b0, 0, "R5 root-level not present", 1'b0);
        write_root(32'h0001_0000);
        send(mkva(12'd3, 10'd5, 10'h1A3), 2'd0, 1'b1, 0, "R3 user read translate", 1'b0);
        send(mkva(12'd3, 10'd5, 10'h1A3), 2'd1, 1'b1, 3, "R3 user write translate", 1'b0);
        send(mkva(12'd3, 10'd5, 10'h011), 2'd2, 1'b1, 0, "R6 missing execute right", 1'b0);
        send(mkva(12'd3, 10'd6, 10'h3FF), 2'd2, 1'b0, 0, "R4 supervisor execute", 1'b0);
        send(mkva(12'd3, 10'd6, 10'h000), 2'd0, 1'b1, 0, "R6 user on supervisor page", 1'b0);
        send(mkva(12'd3, 10'd6, 10'h020), 2'd1, 1'b0, 2, "R6 missing write right", 1'b0);
        send(mkva(12'd3, 10'd5, 10'h020), 2'd3, 1'b0, 0, "R6 access code 3", 1'b0);
        send(mkva(12'd3, 10'd7, 10'h040), 2'd0, 1'b0, 0, "R5 leaf not present", 1'b0);
        send(mkva(12'hFFF, 10'h3FF, 10'h3FF), 2'd0, 1'b0, 0, "R2 all-ones indices", 1'b0);
        send(mkva(12'd3, 10'd5, 10'h000), 2'd0, 1'b1, 1, "R7 busy request ignored", 1'b1);
        send(mkva(12'd3, 10'd5, 10'h002), 2'd0, 1'b1, 0, "R9 busy root write dropped", 1'b0);
        write_root(32'h0004_0000);
        send(mkva(12'd3, 10'd5, 10'h055), 2'd0, 1'b1, 0, "R9 idle root write used", 1'b0);
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0 && !rsp_valid, "R7 no extra response",
              sb_q.size(), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule